// File: doc/BRIEF.md
# Multiplexed CAM Bus Access Sequencer

This block runs one single-byte read or write on an 8-bit bus that carries both address and data to one of two conditional-access interface chips. A request gives the direction, a 16-bit address, the write byte, a one-bit device index and a flag that selects control space or memory space. The block latches the address into the chip in two byte phases. Each phase has its own latch strobe. The block then drives the write byte or releases the data lines, selects the device, and pulses a read or write strobe. It holds the strobe until the chip pulls its active-low acknowledge low, or until a cycle-count timeout expires.

A single-cycle done pulse ends each access. The byte captured from the bus comes back with it, along with an error flag that is set only on timeout. The space flag goes out unchanged and is held for the whole access, so that logic outside the block can apply it before the cycle. Requests use a valid/ready handshake, and the block takes a request only while it is idle. Each setup phase lasts `SETUP_CLKS` clocks. The acknowledge wait lasts at most `ACK_TIMEOUT` clocks; the default is 1 ms at 250 MHz.

Top module: `cam_bus_seq`

## Requirements
- R1: After reset or while idle, `cs_n` is 2'b11, `rd_n` and `wr_n` are 1, both address strobes are 0, `bus_data_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For the next `SETUP_CLKS` clocks, `addr_lo_stb` is 1 and `bus_data_o` carries address bits 7:0. For the following `SETUP_CLKS` clocks, `addr_lo_stb` is 0 and the same byte is held.
- R3: Next, for `SETUP_CLKS` clocks, `addr_hi_stb` is 1 and `bus_data_o` carries address bits 15:8. For another `SETUP_CLKS` clocks, `addr_hi_stb` is 0 and the byte is held. The two address strobes are never 1 together.
- R4: The data lines are driven (`bus_data_oe` = 1) during both address phases. From the data phase onward, a write keeps them driven with the write byte on `bus_data_o`, and a read releases them (`bus_data_oe` = 0) until the access ends.
- R5: From the select phase until completion, device index 0 drives `cs_n` = 2'b10 and index 1 drives `cs_n` = 2'b01. At most one select is ever low.
- R6: Exactly 6*`SETUP_CLKS` clocks after acceptance, the strobe phase begins: `rd_n` goes low for a read, or `wr_n` goes low for a write. The two strobes are never low together.
- R7: `ack_n` passes through a two-flop synchroniser. If `ack_n` is driven low during the strobe phase, `done` rises on the third clock edge after that. `rdata` then holds the `bus_data_i` value that was sampled on that edge, and `err` is 0.
- R8: If no acknowledge arrives, `done` rises on the `ACK_TIMEOUT`-th edge after the strobe phase begins, with `err` = 1. If an acknowledge reaches the synchroniser output on that same edge, the acknowledge wins and `err` = 0.
- R9: In the cycle where `done` is 1, `cs_n` is 2'b11 and `rd_n` and `wr_n` are both 1.
- R10: `req_ready` is 0 from acceptance until completion, so a request raised during an access does not disturb it. Such a request is accepted on the first edge after `done`.
- R11: `space_sel` equals the `req_space` value that was latched at acceptance. It stays stable until the access completes.
- R12: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Target address |
| req_wdata | input | 8 | Write byte |
| req_chip | input | 1 | Device index (0 or 1) |
| req_space | input | 1 | Control-space (1) or memory-space (0) flag |
| space_sel | output | 1 | Latched space flag for the current access |
| bus_data_o | output | 8 | Byte driven on the shared lines |
| bus_data_oe | output | 1 | Output enable for the shared lines |
| bus_data_i | input | 8 | Byte read from the shared lines |
| addr_lo_stb | output | 1 | Low-address latch strobe (active high) |
| addr_hi_stb | output | 1 | High-address latch strobe (active high) |
| cs_n | output | 2 | Active-low device selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from the device |
| done | output | 1 | Access complete pulse |
| err | output | 1 | Access ended on timeout |
| rdata | output | 8 | Byte captured at completion |

## Verification
Each of the six setup phases starts a whole multiple of `SETUP_CLKS` edges after the accepting edge, and the strobe phase begins at edge 6*`SETUP_CLKS`. The bench advances on falling edges and samples each phase in its first cycle. After the bench drops `ack_n`, the done pulse is due on the third rising edge, because two synchroniser flops and the state register lie in the path. Without an acknowledge, the pulse is due on edge `ACK_TIMEOUT` of the strobe phase. The bench checks that `done` is still low on every falling edge before the due edge, high on the due edge and low again one cycle later. One vector places the acknowledge so that it lands on the same edge as the timeout.

// File: rtl/cam_bus_seq.sv
module cam_bus_seq #(
  parameter int SETUP_CLKS  = 2,
  parameter int ACK_TIMEOUT = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_chip,
  input  logic        req_space,
  output logic        space_sel,
  output logic [7:0]  bus_data_o,
  output logic        bus_data_oe,
  input  logic [7:0]  bus_data_i,
  output logic        addr_lo_stb,
  output logic        addr_hi_stb,
  output logic [1:0]  cs_n,
  output logic        rd_n,
  output logic        wr_n,
  input  logic        ack_n,
  output logic        done,
  output logic        err,
  output logic [7:0]  rdata
);

  localparam int PW = (SETUP_CLKS > 1) ? $clog2(SETUP_CLKS) : 1;
  localparam int TW = (ACK_TIMEOUT > 1) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [PW-1:0] PH_LAST  = PW'(SETUP_CLKS - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(ACK_TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ALO, S_ALO_HOLD, S_AHI, S_AHI_HOLD, S_DATA, S_SEL, S_STB
  } st_t;

  st_t           st;
  logic [PW-1:0] ph_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          ack_s1, ack_s2;
  logic          write_q, chip_q, space_q;
  logic [15:0]   addr_q;
  logic [7:0]    wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph_cnt  <= '0;
      tmo_cnt <= '0;
      ack_s1  <= 1'b1;
      ack_s2  <= 1'b1;
      write_q <= 1'b0;
      chip_q  <= 1'b0;
      space_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
    end else begin
      ack_s1 <= ack_n;
      ack_s2 <= ack_s1;
      done   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          write_q <= req_write;
          chip_q  <= req_chip;
          space_q <= req_space;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          ph_cnt  <= '0;
          st      <= S_ALO;
        end
        S_STB: if (!ack_s2 || tmo_cnt == TMO_LAST) begin
          rdata <= bus_data_i;
          err   <= ack_s2;
          done  <= 1'b1;
          st    <= S_IDLE;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
        default: if (ph_cnt == PH_LAST) begin
          ph_cnt  <= '0;
          tmo_cnt <= '0;
          st      <= st_t'(st + 3'd1);
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      endcase
    end
  end

  wire lo_phase  = (st == S_ALO) || (st == S_ALO_HOLD);
  wire hi_phase  = (st == S_AHI) || (st == S_AHI_HOLD);
  wire late      = (st == S_DATA) || (st == S_SEL) || (st == S_STB);
  wire selected  = (st == S_SEL) || (st == S_STB);

  assign req_ready   = (st == S_IDLE);
  assign space_sel   = space_q;
  assign addr_lo_stb = (st == S_ALO);
  assign addr_hi_stb = (st == S_AHI);
  assign bus_data_o  = lo_phase ? addr_q[7:0] : hi_phase ? addr_q[15:8] : wdata_q;
  assign bus_data_oe = lo_phase || hi_phase || (late && write_q);
  assign cs_n        = !selected ? 2'b11 : (chip_q ? 2'b01 : 2'b10);
  assign rd_n        = !((st == S_STB) && !write_q);
  assign wr_n        = !((st == S_STB) && write_q);

endmodule

// File: rtl/cam_bus_seq_chk.sv
module cam_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       space_sel,
  input logic       bus_data_oe,
  input logic       addr_lo_stb,
  input logic       addr_hi_stb,
  input logic [1:0] cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       done
);

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R5
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == 2'b11 && rd_n && wr_n));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  addr_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_lo_stb && addr_hi_stb));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_data_oe);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n == 2'b11 && rd_n && wr_n && !addr_hi_stb));

  // R11
  space_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(space_sel));

endmodule

bind cam_bus_seq cam_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .space_sel(space_sel),
  .bus_data_oe(bus_data_oe), .addr_lo_stb(addr_lo_stb), .addr_hi_stb(addr_hi_stb),
  .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
);

// File: tb/sim_cam_bus_seq.sv
`timescale 1ns/1ps
module sim_cam_bus_seq;
  localparam int S = 2;
  localparam int T = 20;
  localparam int NV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_chip = 1'b0, req_space = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, bus_data_i = '0;
  logic ack_n = 1'b1;
  logic req_ready, space_sel, bus_data_oe, addr_lo_stb, addr_hi_stb, rd_n, wr_n, done, err;
  logic [7:0] bus_data_o, rdata;
  logic [1:0] cs_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cam_bus_seq #(.SETUP_CLKS(S), .ACK_TIMEOUT(T)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_chip(req_chip), .req_space(req_space), .space_sel(space_sel),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i),
    .addr_lo_stb(addr_lo_stb), .addr_hi_stb(addr_hi_stb), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n), .done(done), .err(err), .rdata(rdata)
  );

  // {write, chip, space, addr, wdata, rdbus, ack_delay}; ack_delay 255 = never
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h12A5, 8'h00, 8'h3C, 8'd0},
    {1'b1, 1'b1, 1'b1, 16'hBEEF, 8'h5A, 8'h00, 8'd4},
    {1'b0, 1'b1, 1'b1, 16'h0081, 8'h00, 8'hC7, 8'd255},
    {1'b1, 1'b0, 1'b0, 16'hFF00, 8'hA3, 8'h00, 8'd255},
    {1'b0, 1'b0, 1'b1, 16'h7E18, 8'h00, 8'h96, 8'd17},
    {1'b1, 1'b1, 1'b0, 16'h0001, 8'hFF, 8'h00, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      summary();
    end
  end

  task automatic run(input logic [42:0] v);
    logic wr, ch, sp;
    logic [15:0] a;
    logic [7:0] wd, rb, dly;
    int due;
    logic [1:0] cs_exp;
    {wr, ch, sp, a, wd, rb, dly} = v;
    cs_exp = ch ? 2'b01 : 2'b10;
    req_write = wr; req_chip = ch; req_space = sp; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // phase 0: low address strobe
    chk(addr_lo_stb && bus_data_o == a[7:0] && bus_data_oe, "R2", "lo set", bus_data_o, a[7:0]);
    chk(!req_ready, "R10", "ready busy", req_ready, 0);
    chk(space_sel == sp, "R11", "space", space_sel, sp);
    repeat (S) @(negedge clk);
    chk(!addr_lo_stb && bus_data_o == a[7:0], "R2", "lo hold", addr_lo_stb, 0);
    repeat (S) @(negedge clk);
    chk(addr_hi_stb && !addr_lo_stb && bus_data_o == a[15:8], "R3", "hi set", bus_data_o, a[15:8]);
    repeat (S) @(negedge clk);
    chk(!addr_hi_stb && bus_data_o == a[15:8] && bus_data_oe, "R3", "hi hold", addr_hi_stb, 0);
    repeat (S) @(negedge clk);
    chk(bus_data_oe == wr, "R4", "data oe", bus_data_oe, wr);
    if (wr) chk(bus_data_o == wd, "R4", "wdata", bus_data_o, wd);
    chk(cs_n == 2'b11 && rd_n && wr_n, "R6", "no strobe yet", cs_n, 3);
    repeat (S) @(negedge clk);
    chk(cs_n == cs_exp, "R5", "select", cs_n, cs_exp);
    chk(rd_n && wr_n, "R6", "strobe early", {rd_n, wr_n}, 3);
    repeat (S) @(negedge clk);
    chk(rd_n == wr && wr_n == !wr, "R6", "strobe", {rd_n, wr_n}, {wr, !wr});
    chk(cs_n == cs_exp && bus_data_oe == wr, "R4", "strobe oe", bus_data_oe, wr);
    bus_data_i = rb;
    due = (dly == 8'd255) ? T : int'(dly) + 3;
    if (dly == 8'd0) ack_n = 1'b0;
    for (int k = 1; k <= due; k++) begin
      @(negedge clk);
      if (k == int'(dly)) ack_n = 1'b0;
      if (k < due) chk(!done && !req_ready, "R7", "done early", done, 0);
    end
    chk(done, (dly == 8'd255) ? "R8" : "R7", "done due", done, 1);
    chk(err == (dly == 8'd255), "R8", "err", err, dly == 8'd255);
    chk(cs_n == 2'b11 && rd_n && wr_n, "R9", "release", {cs_n, rd_n, wr_n}, 15);
    chk(space_sel == sp, "R11", "space at done", space_sel, sp);
    if (!wr) chk(rdata == rb, "R7", "rdata", rdata, rb);
    ack_n = 1'b1;
    @(negedge clk);
    chk(!done, "R12", "pulse", done, 0);
    chk(req_ready && cs_n == 2'b11 && !bus_data_oe, "R1", "idle after", req_ready, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11 && rd_n && wr_n, "R1", "reset ctl", {cs_n, rd_n, wr_n}, 15);
    chk(req_ready && !done && !bus_data_oe && !addr_lo_stb && !addr_hi_stb, "R1", "reset misc",
        {req_ready, done, bus_data_oe}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R10: request raised mid-access is taken only after done
    req_write = 1'b0; req_chip = 1'b0; req_space = 1'b0;
    req_addr = 16'h4433; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 16'h9966;
    repeat (6 * S) @(negedge clk);
    chk(!rd_n && !req_ready, "R10", "first still running", rd_n, 0);
    ack_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done, "R10", "first done", done, 1);
    ack_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_lo_stb && bus_data_o == 8'h66, "R10", "second accepted", bus_data_o, 8'h66);
    repeat (6 * S) @(negedge clk);
    chk(!rd_n, "R6", "second strobe", rd_n, 0);
    // reset during strobe returns controls idle at once
    rst_n = 1'b0;
    #1;
    chk(cs_n == 2'b11 && rd_n && req_ready, "R1", "reset mid", {cs_n, rd_n}, 7);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule